// File: doc/BRIEF.md
# Load/Store Port Requester Sequencer

This block is the master on the compute side of a single load/store port. A local client hands it one command at a time: a start strobe, a load-or-store select, an address, a byte length and, for stores, the data word. The sequencer then follows the port's busy/acknowledge handshake until the operation completes. It returns a one-cycle done pulse, a registered load result, and an exception flag when the port refuses the address.

The handshake expects the requester to keep the address until the port releases it. The sequencer first waits for the port's busy output to go low. It then raises exactly one request line together with address-valid and holds both, with a stable address, for as long as the port stays busy. It waits for a one-cycle acknowledge or a one-cycle exception. After an acknowledge, a load waits any number of cycles for a one-cycle load-valid strobe and captures the data on that strobe. A store sends one store-valid pulse carrying the data, then waits one more cycle for busy to fall. An abort input returns the sequencer to idle from any state.

Top module: `lsreq_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cmd_ready_o` is 1 and every port request, valid and data output, `cmd_done_o`, `cmd_exc_o` and `cmd_rdata_o` are 0.
- R2: A start accepted while `pt_busy_i` is high raises no request; the request lines rise only in the cycle after a cycle in which busy was sampled low. `cmd_ready_o` is 1 exactly when no operation is in progress.
- R3: During an operation exactly one of `pt_ld_req_o` / `pt_st_req_o` is high, chosen by `cmd_store_i` (1 = store) at the accepted start, and it rises together with `pt_addr_vld_o`.
- R4: `pt_addr_o` and `pt_len_o` carry the address and the 4-bit length (legal values 1, 2, 4, 8) captured at start. `pt_addr_vld_o`, the request, the address and the length stay high and stable while the port holds busy.
- R5: An address exception sampled while the request is outstanding ends the operation with no store pulse and no memory update. All request outputs fall in the next cycle, together with a done pulse.
- R6: For a load, the data on `pt_ld_data_i` in the cycle `pt_ld_vld_i` is high (in the acknowledge cycle or at any later cycle) appears on `cmd_rdata_o` in the next cycle, together with a done pulse, and is held afterwards.
- R7: For a store, `pt_st_vld_o` is high for exactly one cycle, in the cycle right after the acknowledge was sampled.
- R8: A store completes with a one-cycle `cmd_done_o` in the cycle after the first cycle following the pulse in which busy is sampled low.
- R9: `cmd_exc_o` is set by an address exception and stays set until the next accepted start clears it.
- R10: `abort_i` sampled high puts the sequencer in idle in the next cycle, with all request and valid outputs low and no done pulse; it overrides a start in the same cycle.
- R11: Start pulses and changes on the command inputs while an operation is in progress are ignored: the port keeps the captured address and data.
- R12: With `ST_DATA_GATE` = 1 (default), `pt_st_data_o` is zero outside the store pulse and equals the captured store data during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_i | input | 1 | Return to idle, drop all requests |
| cmd_start_i | input | 1 | Begin a command (taken when ready) |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W | Access address |
| cmd_len_i | input | LEN_W | Access length in bytes |
| cmd_wdata_i | input | DATA_W | Store data |
| cmd_ready_o | output | 1 | Idle, a start is accepted |
| cmd_done_o | output | 1 | One-cycle completion pulse |
| cmd_exc_o | output | 1 | Last operation hit an address exception |
| cmd_rdata_o | output | DATA_W | Registered load result |
| pt_busy_i | input | 1 | Port has an operation in flight |
| pt_ld_req_o | output | 1 | Load request |
| pt_st_req_o | output | 1 | Store request |
| pt_len_o | output | LEN_W | Access length to the port |
| pt_addr_o | output | ADDR_W | Address to the port |
| pt_addr_vld_o | output | 1 | Address valid |
| pt_addr_ack_i | input | 1 | Address accepted (one cycle) |
| pt_addr_exc_i | input | 1 | Address refused (one cycle) |
| pt_ld_vld_i | input | 1 | Load data valid (one cycle) |
| pt_ld_data_i | input | DATA_W | Load data |
| pt_st_vld_o | output | 1 | Store data valid pulse |
| pt_st_data_o | output | DATA_W | Store data |

## Verification
A corrupted sequencer state shows at the port in the very next cycle. The request, address-valid or store-valid lines take the wrong shape: a valid that falls while busy is still high, a second store pulse, or a request raised under busy. A wrong captured command register shows as a mismatched address or length while address-valid is high, or as wrong data in the store pulse. A missing or extra done, or a stale result or exception flag, shows one cycle after the port strobe that should have caused it. The bench's port responder varies the acknowledge latency, the load latency and the exception path, so each of these windows is visible.

// File: rtl/lsreq_pkg.sv
package lsreq_pkg;

   // Sequencer phases; the numeric order carries no meaning
   typedef enum logic [2:0] {
      SQ_IDLE    = 3'd0,   // waiting for a command
      SQ_HOLD    = 3'd1,   // command taken, port still busy
      SQ_ISSUE   = 3'd2,   // request and address presented
      SQ_LDWAIT  = 3'd3,   // address taken, waiting for load data
      SQ_STPULSE = 3'd4,   // store data pulse
      SQ_STDRAIN = 3'd5    // waiting for busy to fall after the pulse
   } seq_phase_e;

   // Byte counts the port understands
   function automatic logic len_is_legal(input logic [3:0] n);
      return (n == 4'd1) || (n == 4'd2) || (n == 4'd4) || (n == 4'd8);
   endfunction

endpackage

// File: rtl/lsreq_cmd_hold.sv
module lsreq_cmd_hold #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic              store_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              store_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LEN_W-1:0]  len_o,
   output logic [DATA_W-1:0] wdata_o
);
   import lsreq_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_o <= 1'b0;
         addr_o  <= '0;
         len_o   <= '0;
         wdata_o <= '0;
      end else if (capture_i) begin
         store_o <= store_i;
         addr_o  <= addr_i;
         len_o   <= len_i;
         wdata_o <= wdata_i;
      end
   end

   // R4
   legal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |-> len_is_legal(4'(len_i)));

endmodule

// File: rtl/lsreq_ctrl.sv
module lsreq_ctrl (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    abort_i,
   input  logic                    start_i,
   input  logic                    store_q_i,
   input  logic                    busy_i,
   input  logic                    ack_i,
   input  logic                    exc_i,
   input  logic                    ldv_i,
   output lsreq_pkg::seq_phase_e   phase_o,
   output logic                    capture_o,
   output logic                    done_evt_o,
   output logic                    exc_evt_o,
   output logic                    ld_take_o
);
   import lsreq_pkg::*;

   seq_phase_e phase_q, phase_d;

   always_comb begin
      phase_d = phase_q;
      if (abort_i) begin
         phase_d = SQ_IDLE;
      end else begin
         unique case (phase_q)
            SQ_IDLE:    if (start_i) phase_d = busy_i ? SQ_HOLD : SQ_ISSUE;
            SQ_HOLD:    if (!busy_i) phase_d = SQ_ISSUE;
            SQ_ISSUE: begin
               if (exc_i)            phase_d = SQ_IDLE;
               else if (ack_i) begin
                  if (store_q_i)     phase_d = SQ_STPULSE;
                  else if (ldv_i)    phase_d = SQ_IDLE;
                  else               phase_d = SQ_LDWAIT;
               end
            end
            SQ_LDWAIT:  if (ldv_i)   phase_d = SQ_IDLE;
            SQ_STPULSE:              phase_d = SQ_STDRAIN;
            SQ_STDRAIN: if (!busy_i) phase_d = SQ_IDLE;
            default:                 phase_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= SQ_IDLE;
      else        phase_q <= phase_d;
   end

   logic in_issue;
   assign in_issue = (phase_q == SQ_ISSUE);

   assign capture_o  = (phase_q == SQ_IDLE) && start_i && !abort_i;
   assign exc_evt_o  = !abort_i && in_issue && exc_i;
   assign ld_take_o  = !abort_i && !store_q_i &&
                       ((in_issue && !exc_i && ack_i && ldv_i) ||
                        (phase_q == SQ_LDWAIT && ldv_i));
   assign done_evt_o = exc_evt_o || ld_take_o ||
                       (!abort_i && phase_q == SQ_STDRAIN && !busy_i);
   assign phase_o    = phase_q;

   // R2
   issue_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == SQ_ISSUE && $past(phase_q) != SQ_ISSUE) |-> !$past(busy_i));

   // R5
   exc_ends_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_issue && exc_i) |=> (phase_q == SQ_IDLE));

endmodule

// File: rtl/lsreq_result.sv
module lsreq_result #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              done_evt_i,
   input  logic              exc_evt_i,
   input  logic              ld_take_i,
   input  logic [DATA_W-1:0] ld_data_i,
   output logic              done_o,
   output logic              exc_o,
   output logic [DATA_W-1:0] rdata_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         exc_o   <= 1'b0;
         rdata_o <= '0;
      end else begin
         done_o <= done_evt_i;
         if (clear_i)        exc_o <= 1'b0;
         else if (exc_evt_i) exc_o <= 1'b1;
         if (ld_take_i)      rdata_o <= ld_data_i;
      end
   end

   // R9
   exc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_o && !clear_i) |=> exc_o);

   // R6
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_take_i |=> $stable(rdata_o));

endmodule

// File: rtl/lsreq_seq.sv
module lsreq_seq #(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 64,
   parameter int LEN_W        = 4,
   parameter bit ST_DATA_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_i,
   input  logic              cmd_start_i,
   input  logic              cmd_store_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [LEN_W-1:0]  cmd_len_i,
   input  logic [DATA_W-1:0] cmd_wdata_i,
   output logic              cmd_ready_o,
   output logic              cmd_done_o,
   output logic              cmd_exc_o,
   output logic [DATA_W-1:0] cmd_rdata_o,
   input  logic              pt_busy_i,
   output logic              pt_ld_req_o,
   output logic              pt_st_req_o,
   output logic [LEN_W-1:0]  pt_len_o,
   output logic [ADDR_W-1:0] pt_addr_o,
   output logic              pt_addr_vld_o,
   input  logic              pt_addr_ack_i,
   input  logic              pt_addr_exc_i,
   input  logic              pt_ld_vld_i,
   input  logic [DATA_W-1:0] pt_ld_data_i,
   output logic              pt_st_vld_o,
   output logic [DATA_W-1:0] pt_st_data_o
);
   import lsreq_pkg::*;

   localparam int DATA_BYTES = DATA_W / 8;

   // Elaboration-time parameter checks
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("lsreq_seq: DATA_W must be a whole number of bytes");
   end
   if (LEN_W != 4) begin : g_bad_len_w
      $error("lsreq_seq: LEN_W must be 4");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("lsreq_seq: ADDR_W must be positive");
   end
   if (DATA_BYTES > 8) begin : g_bad_bytes
      $error("lsreq_seq: a length field of 8 bytes cannot cover DATA_W");
   end

   seq_phase_e        phase;
   logic              capture, done_evt, exc_evt, ld_take;
   logic              store_q;
   logic [DATA_W-1:0] wdata_q;

   lsreq_cmd_hold #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .store_i   (cmd_store_i),
      .addr_i    (cmd_addr_i),
      .len_i     (cmd_len_i),
      .wdata_i   (cmd_wdata_i),
      .store_o   (store_q),
      .addr_o    (pt_addr_o),
      .len_o     (pt_len_o),
      .wdata_o   (wdata_q)
   );

   lsreq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort_i    (abort_i),
      .start_i    (cmd_start_i),
      .store_q_i  (store_q),
      .busy_i     (pt_busy_i),
      .ack_i      (pt_addr_ack_i),
      .exc_i      (pt_addr_exc_i),
      .ldv_i      (pt_ld_vld_i),
      .phase_o    (phase),
      .capture_o  (capture),
      .done_evt_o (done_evt),
      .exc_evt_o  (exc_evt),
      .ld_take_o  (ld_take)
   );

   lsreq_result #(
      .DATA_W (DATA_W)
   ) u_result (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (capture),
      .done_evt_i (done_evt),
      .exc_evt_i  (exc_evt),
      .ld_take_i  (ld_take),
      .ld_data_i  (pt_ld_data_i),
      .done_o     (cmd_done_o),
      .exc_o      (cmd_exc_o),
      .rdata_o    (cmd_rdata_o)
   );

   // Port-side decode of the phase
   logic active;
   assign active        = (phase == SQ_ISSUE)   || (phase == SQ_LDWAIT) ||
                          (phase == SQ_STPULSE) || (phase == SQ_STDRAIN);
   assign pt_addr_vld_o = active;
   assign pt_ld_req_o   = active && !store_q;
   assign pt_st_req_o   = active &&  store_q;
   assign pt_st_vld_o   = (phase == SQ_STPULSE);
   assign cmd_ready_o   = (phase == SQ_IDLE);

   if (ST_DATA_GATE) begin : g_st_gated
      assign pt_st_data_o = pt_st_vld_o ? wdata_q : '0;
   end else begin : g_st_open
      assign pt_st_data_o = wdata_q;
   end

   // R3
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pt_ld_req_o && pt_st_req_o));

   // R4
   addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pt_addr_vld_o && pt_busy_i && !abort_i) |=>
         (pt_addr_vld_o && $stable(pt_addr_o) && $stable(pt_len_o)));

   // R7
   st_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pt_st_vld_o |=> !pt_st_vld_o);

   // R7
   st_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pt_st_vld_o) |-> $past(pt_addr_ack_i));

   // R10
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!pt_addr_vld_o && !pt_ld_req_o && !pt_st_req_o &&
                   !pt_st_vld_o && !cmd_done_o && cmd_ready_o));

endmodule

// File: tb/lsreq_seq_test.sv
`timescale 1ns/1ps
module lsreq_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 64;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          abort_i = 1'b0;
   logic          cmd_start_i = 1'b0;
   logic          cmd_store_i = 1'b0;
   logic [AW-1:0] cmd_addr_i = '0;
   logic [LW-1:0] cmd_len_i = 4'd8;
   logic [DW-1:0] cmd_wdata_i = '0;
   logic          cmd_ready_o, cmd_done_o, cmd_exc_o;
   logic [DW-1:0] cmd_rdata_o;
   logic          pt_busy_i = 1'b0;
   logic          pt_ld_req_o, pt_st_req_o, pt_addr_vld_o, pt_st_vld_o;
   logic [LW-1:0] pt_len_o;
   logic [AW-1:0] pt_addr_o;
   logic          pt_addr_ack_i = 1'b0;
   logic          pt_addr_exc_i = 1'b0;
   logic          pt_ld_vld_i = 1'b0;
   logic [DW-1:0] pt_ld_data_i = '0;
   logic [DW-1:0] pt_st_data_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsreq_seq uut (
      .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
      .cmd_start_i(cmd_start_i), .cmd_store_i(cmd_store_i),
      .cmd_addr_i(cmd_addr_i), .cmd_len_i(cmd_len_i), .cmd_wdata_i(cmd_wdata_i),
      .cmd_ready_o(cmd_ready_o), .cmd_done_o(cmd_done_o), .cmd_exc_o(cmd_exc_o),
      .cmd_rdata_o(cmd_rdata_o), .pt_busy_i(pt_busy_i),
      .pt_ld_req_o(pt_ld_req_o), .pt_st_req_o(pt_st_req_o), .pt_len_o(pt_len_o),
      .pt_addr_o(pt_addr_o), .pt_addr_vld_o(pt_addr_vld_o),
      .pt_addr_ack_i(pt_addr_ack_i), .pt_addr_exc_i(pt_addr_exc_i),
      .pt_ld_vld_i(pt_ld_vld_i), .pt_ld_data_i(pt_ld_data_i),
      .pt_st_vld_o(pt_st_vld_o), .pt_st_data_o(pt_st_data_o)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural port responder ----------------
   int  cfg_ack_lat = 1;     // cycles from accept to ack/exc
   int  cfg_ld_lat  = 2;     // 0: load data with the ack
   bit  cfg_exc     = 1'b0;  // refuse the address
   bit  hold_busy   = 1'b0;  // foreign traffic keeps the port busy
   logic [DW-1:0] mem [16];
   int  pst = 0;
   int  pcnt = 0;

   initial for (int i = 0; i < 16; i++) mem[i] = '0;

   always @(negedge clk) begin
      #1;
      pt_addr_ack_i = 1'b0;
      pt_addr_exc_i = 1'b0;
      pt_ld_vld_i   = 1'b0;
      if (pst != 0 && pst != 5 && !pt_addr_vld_o) begin
         pst = 0;                       // request withdrawn (abort)
      end
      case (pst)
         0: begin
            pt_busy_i = hold_busy;
            if (!hold_busy && pt_addr_vld_o && (pt_ld_req_o || pt_st_req_o)) begin
               pt_busy_i = 1'b1;
               pcnt = cfg_ack_lat;
               pst = 1;
            end
         end
         1: begin
            if (pcnt > 1) pcnt--;
            else if (cfg_exc) begin
               pt_addr_exc_i = 1'b1; pt_busy_i = 1'b0; pst = 0;
            end else begin
               pt_addr_ack_i = 1'b1;
               if (pt_st_req_o) pst = 3;
               else if (cfg_ld_lat == 0) begin
                  pt_ld_vld_i = 1'b1; pt_ld_data_i = mem[pt_addr_o[3:0]];
                  pt_busy_i = 1'b0; pst = 0;
               end else begin
                  pcnt = cfg_ld_lat; pst = 2;
               end
            end
         end
         2: begin
            if (pcnt > 1) pcnt--;
            else begin
               pt_ld_vld_i = 1'b1; pt_ld_data_i = mem[pt_addr_o[3:0]];
               pt_busy_i = 1'b0; pst = 0;
            end
         end
         3: if (pt_st_vld_o) begin
               mem[pt_addr_o[3:0]] = pt_st_data_o;
               pst = 5;
            end
         5: begin pt_busy_i = 1'b0; pst = 0; end
         default: pst = 0;
      endcase
   end

   // ---------------- reference model ----------------
   int            m_ph = 0;
   bit            m_store = 0, m_done = 0, m_exc = 0;
   logic [AW-1:0] m_addr = '0;
   logic [LW-1:0] m_len = '0;
   logic [DW-1:0] m_wdata = '0, m_rdata = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_store = 0; m_done = 0; m_exc = 0;
         m_addr = '0; m_len = '0; m_wdata = '0; m_rdata = '0;
      end else begin
         m_done = 0;
         if (abort_i) m_ph = 0;
         else case (m_ph)
            0: if (cmd_start_i) begin
                  m_store = cmd_store_i; m_addr = cmd_addr_i;
                  m_len = cmd_len_i; m_wdata = cmd_wdata_i; m_exc = 0;
                  m_ph = pt_busy_i ? 1 : 2;
               end
            1: if (!pt_busy_i) m_ph = 2;
            2: if (pt_addr_exc_i) begin m_ph = 0; m_done = 1; m_exc = 1; end
               else if (pt_addr_ack_i) begin
                  if (m_store) m_ph = 4;
                  else if (pt_ld_vld_i) begin m_rdata = pt_ld_data_i; m_done = 1; m_ph = 0; end
                  else m_ph = 3;
               end
            3: if (pt_ld_vld_i) begin m_rdata = pt_ld_data_i; m_done = 1; m_ph = 0; end
            4: m_ph = 5;
            5: if (!pt_busy_i) begin m_done = 1; m_ph = 0; end
            default: m_ph = 0;
         endcase
      end
   end

   int st_pulses = 0;
   int done_seen = 0;
   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         bit act;
         act = (m_ph >= 2);
         check("R2",  "ready",    DW'(cmd_ready_o),   DW'(m_ph == 0));
         check("R3",  "ld_req",   DW'(pt_ld_req_o),   DW'(act && !m_store));
         check("R3",  "st_req",   DW'(pt_st_req_o),   DW'(act && m_store));
         check("R4",  "addr_vld", DW'(pt_addr_vld_o), DW'(act));
         if (act) begin
            check("R4", "addr", DW'(pt_addr_o), DW'(m_addr));
            check("R4", "len",  DW'(pt_len_o),  DW'(m_len));
         end
         check("R7",  "st_vld",   DW'(pt_st_vld_o),   DW'(m_ph == 4));
         check("R12", "st_data",  pt_st_data_o,       (m_ph == 4) ? m_wdata : '0);
         check("R8",  "done",     DW'(cmd_done_o),    DW'(m_done));
         check("R6",  "rdata",    cmd_rdata_o,        m_rdata);
         check("R9",  "exc",      DW'(cmd_exc_o),     DW'(m_exc));
         if (pt_st_vld_o) st_pulses++;
         if (cmd_done_o)  done_seen++;
      end
   end

   // ---------------- watchdog ----------------
   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic wait_idle();
      for (int i = 0; i < 200 && m_ph != 0; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_op(input bit st, input logic [AW-1:0] a, input logic [LW-1:0] n,
                         input logic [DW-1:0] d, input int ackl, input int ldl, input bit ex);
      @(negedge clk);
      cfg_ack_lat = ackl; cfg_ld_lat = ldl; cfg_exc = ex;
      cmd_store_i = st; cmd_addr_i = a; cmd_len_i = n; cmd_wdata_i = d;
      cmd_start_i = 1'b1;
      @(negedge clk);
      cmd_start_i = 1'b0;
      wait_idle();
   endtask

   initial begin
      int p0, d0;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "ready in reset", DW'(cmd_ready_o), 1);
      check("R1", "requests in reset",
            DW'({pt_ld_req_o, pt_st_req_o, pt_addr_vld_o, pt_st_vld_o}), 0);
      check("R1", "result in reset", DW'({cmd_done_o, cmd_exc_o}) | cmd_rdata_o, 0);
      check("R12", "st_data in reset", pt_st_data_o, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "ready after reset", DW'(cmd_ready_o), 1);

      // R7 R8: stores with different ack latencies
      p0 = st_pulses;
      run_op(1'b1, 32'h2, 4'd2, 64'hbeef, 1, 1, 1'b0);
      check("R7", "one store pulse", DW'(st_pulses - p0), 1);
      run_op(1'b1, 32'h4, 4'd8, 64'h0123_4567_89ab_cdef, 4, 1, 1'b0);
      // R6: loads, late data and data with the ack
      run_op(1'b0, 32'h2, 4'd2, '0, 2, 5, 1'b0);
      check("R6", "load result addr 2", cmd_rdata_o, 64'hbeef);
      run_op(1'b0, 32'h4, 4'd8, '0, 1, 0, 1'b0);
      check("R6", "load result with ack", cmd_rdata_o, 64'h0123_4567_89ab_cdef);

      // R5 R9: refused store leaves memory untouched, flag sticks
      p0 = st_pulses;
      run_op(1'b1, 32'h2, 4'd4, 64'hdead, 3, 1, 1'b0 | 1'b1);
      check("R5", "no pulse on exception", DW'(st_pulses - p0), 0);
      check("R9", "exc set", DW'(cmd_exc_o), 1);
      repeat (5) @(negedge clk);
      check("R9", "exc held", DW'(cmd_exc_o), 1);
      run_op(1'b0, 32'h2, 4'd2, '0, 1, 2, 1'b0);
      check("R5", "memory unchanged after exception", cmd_rdata_o, 64'hbeef);
      check("R9", "exc cleared by start", DW'(cmd_exc_o), 0);

      // R2: port busy with foreign traffic at start
      @(negedge clk);
      hold_busy = 1'b1;
      cfg_ack_lat = 1; cfg_ld_lat = 1; cfg_exc = 1'b0;
      cmd_store_i = 1'b0; cmd_addr_i = 32'h4; cmd_len_i = 4'd8; cmd_start_i = 1'b1;
      @(negedge clk);
      cmd_start_i = 1'b0;
      repeat (4) @(negedge clk);
      check("R2", "no request while busy", DW'(pt_ld_req_o | pt_addr_vld_o), 0);
      check("R2", "not ready while waiting", DW'(cmd_ready_o), 0);
      hold_busy = 1'b0;
      wait_idle();
      check("R6", "load after busy wait", cmd_rdata_o, 64'h0123_4567_89ab_cdef);

      // R11: command inputs ignored mid-operation
      @(negedge clk);
      cfg_ack_lat = 3; cfg_exc = 1'b0;
      cmd_store_i = 1'b1; cmd_addr_i = 32'h7; cmd_len_i = 4'd1;
      cmd_wdata_i = 64'h55; cmd_start_i = 1'b1;
      @(negedge clk);
      cmd_start_i = 1'b0;
      @(negedge clk);
      cmd_addr_i = 32'h9; cmd_wdata_i = 64'haa; cmd_store_i = 1'b0; cmd_start_i = 1'b1;
      @(negedge clk);
      cmd_start_i = 1'b0;
      check("R11", "address kept", DW'(pt_addr_o), 64'h7);
      wait_idle();
      run_op(1'b0, 32'h7, 4'd1, '0, 1, 1, 1'b0);
      check("R11", "stored data kept", cmd_rdata_o, 64'h55);
      run_op(1'b0, 32'h9, 4'd1, '0, 1, 1, 1'b0);
      check("R11", "second address untouched", cmd_rdata_o, 64'h0);

      // R10: abort while waiting for the acknowledge
      d0 = done_seen;
      @(negedge clk);
      cfg_ack_lat = 10;
      cmd_store_i = 1'b0; cmd_addr_i = 32'h2; cmd_len_i = 4'd2; cmd_start_i = 1'b1;
      @(negedge clk);
      cmd_start_i = 1'b0;
      repeat (3) @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      check("R10", "idle after abort", DW'(cmd_ready_o), 1);
      check("R10", "requests low after abort",
            DW'({pt_ld_req_o, pt_st_req_o, pt_addr_vld_o}), 0);
      repeat (3) @(negedge clk);
      check("R10", "no done on abort", DW'(done_seen - d0), 0);

      // R10: abort wins over a start in the same cycle
      @(negedge clk);
      cmd_start_i = 1'b1; abort_i = 1'b1;
      @(negedge clk);
      cmd_start_i = 1'b0; abort_i = 1'b0;
      check("R10", "start ignored under abort", DW'(cmd_ready_o), 1);

      // R3: store then load back to back at minimum latency
      run_op(1'b1, 32'hc, 4'd8, 64'hf00f, 1, 1, 1'b0);
      run_op(1'b0, 32'hc, 4'd8, '0, 1, 1, 1'b0);
      check("R3", "store then load round trip", cmd_rdata_o, 64'hf00f);

      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule